// File: doc/BRIEF.md
# Strobe-Triggered Timestamp Capture Unit

This block runs a free-running network time counter that advances once per reference tick (a one-cycle enable derived from the 32.768 kHz reference). The counter keeps advancing through low-power periods. A snapshot of the counter can be taken in two ways. The precise way is hardware capture on the release, meaning the rising edge, of an active-low strobe pin. The coarse way is a read request pulse from the host packet decoder, which is captured in the cycle the request is handled.

After a capture the block raises a report request toward a serial transmitter. It holds the captured value and its source until the transmitter acknowledges. While a report is pending, further strobe activity and read requests are absorbed and change nothing. Strobe pulses that stay low for less than a set number of reference ticks are treated as glitches.

Top module: `strobe_ts_capture`

## Requirements
- R1: During and after reset, `rpt_req` is 0, `rpt_time` is 0, `rpt_src` is 0, and the time counter starts from 0.
- R2: The time counter increases by exactly one at every clock edge where `tick` is 1, and holds otherwise.
- R3: The strobe passes through two synchronizing flops. A release (rising edge) driven on `strobe_n` raises `rpt_req` at the third clock edge after it. At that edge `rpt_time` takes the counter value as it stood before that edge's increment, and `rpt_src` becomes 1 (1 = pin, 0 = read request).
- R4: A falling edge of `strobe_n` alone never starts a capture.
- R5: A release produces a capture only if the synchronized strobe was low for at least `MIN_LOW_TICKS` ticks. Shorter pulses leave all outputs unchanged.
- R6: A `sw_req` pulse while no report is pending captures the counter at that edge. `rpt_req` rises at that edge with `rpt_src` = 0.
- R7: When a valid release and `sw_req` fall on the same edge, the pin capture wins (`rpt_src` = 1). One acknowledge then ends that single report.
- R8: While `rpt_req` is 1, strobe releases and `sw_req` pulses are ignored, and `rpt_time` and `rpt_src` stay stable.
- R9: `rpt_ack` while `rpt_req` is 1 clears `rpt_req` at that edge. No capture is taken on the acknowledge edge. `rpt_ack` without a pending report has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick enable, one cycle per reference period |
| strobe_n | input | 1 | Active-low capture strobe, asynchronous |
| sw_req | input | 1 | Read-time request pulse from packet decoder |
| rpt_ack | input | 1 | Transmitter has taken the report |
| rpt_req | output | 1 | Report pending |
| rpt_time | output | TS_W | Captured counter value |
| rpt_src | output | 1 | Capture source: 1 pin, 0 read request |

## Verification
A stale or corrupted time counter only becomes visible at the ports when a capture happens. For that reason read requests are issued at several points, so that a counter off by one shows up on the next report. A broken glitch counter or synchronizer shows up within three cycles of a release, as a missing report, a spurious report, or a report one cycle early or late. A lockout fault shows up as `rpt_time` changing while a report is pending. The bench's reference model is compared against every output on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/strobe_ts_capture.sv
module strobe_ts_capture #(
  parameter int unsigned TS_W          = 48,
  parameter int unsigned MIN_LOW_TICKS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            strobe_n,
  input  logic            sw_req,
  input  logic            rpt_ack,
  output logic            rpt_req,
  output logic [TS_W-1:0] rpt_time,
  output logic            rpt_src
);
  localparam int unsigned LW = $clog2(MIN_LOW_TICKS + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW_TICKS);

  logic            s_meta, s_sync, s_prev;
  logic [LW-1:0]   low_cnt;
  logic [TS_W-1:0] now_cnt;

  wire sync_rise = s_sync & ~s_prev;
  wire pin_fire  = sync_rise & (low_cnt == LOW_MAX) & ~rpt_req;
  wire sw_fire   = sw_req & ~rpt_req & ~pin_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_meta <= 1'b1;
      s_sync <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s_meta <= strobe_n;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (s_sync)                     low_cnt <= '0;
    else if (tick && low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    now_cnt <= '0;
    else if (tick) now_cnt <= now_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_req  <= 1'b0;
      rpt_time <= '0;
      rpt_src  <= 1'b0;
    end else if (pin_fire || sw_fire) begin
      rpt_req  <= 1'b1;
      rpt_time <= now_cnt;
      rpt_src  <= pin_fire;
    end else if (rpt_ack) begin
      rpt_req  <= 1'b0;
    end
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> now_cnt == $past(now_cnt) + 1'b1);
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(now_cnt));
  a_r4_fall_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (s_prev && !s_sync && !sw_req && !rpt_req) |=> !rpt_req);
  a_r5_short_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && low_cnt != LOW_MAX && !sw_req && !rpt_req) |=> !rpt_req);
  a_r6_sw_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !rpt_req && !sync_rise) |=> rpt_req && !rpt_src);
  a_r8_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_req && !rpt_ack) |=> rpt_req && $stable(rpt_time) && $stable(rpt_src));
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_req && rpt_ack) |=> !rpt_req);
endmodule

// File: tb/strobe_ts_capture_bench.sv
module strobe_ts_capture_bench;
  localparam int unsigned TS_W = 48;
  localparam int unsigned MINL = 5;

  logic clk = 1'b0;
  logic rst_n, tick, strobe_n, sw_req, rpt_ack;
  logic rpt_req, rpt_src;
  logic [TS_W-1:0] rpt_time;

  always #10 clk = ~clk;

  strobe_ts_capture #(.TS_W(TS_W), .MIN_LOW_TICKS(MINL)) u_strobe_ts_capture (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe_n(strobe_n), .sw_req(sw_req),
    .rpt_ack(rpt_ack), .rpt_req(rpt_req), .rpt_time(rpt_time), .rpt_src(rpt_src));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference: strobe history queue plus integer counters
  int     hist[$];
  int     m_low;
  longint m_cnt, m_time;
  bit     m_req, m_src;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(input int sn, input bit sw, input bit ack, input bit tk);
    int  sy, pv;
    bit  pin, swf;
    sy  = hist[1];
    pv  = hist[2];
    pin = (pv == 0) && (sy == 1) && (m_low >= MINL) && !m_req;
    swf = sw && !m_req && !pin;
    if (pin || swf) begin
      m_req  = 1;
      m_time = m_cnt;
      m_src  = pin;
    end else if (ack && m_req) m_req = 0;
    if (sy == 1) m_low = 0;
    else if (tk && m_low < MINL) m_low++;
    if (tk) m_cnt = (m_cnt + 1) & ((64'd1 << TS_W) - 1);
    hist.push_front(sn);
    void'(hist.pop_back());
  endtask

  task automatic step(input logic sn, input bit sw, input bit ack, input string tag);
    bit tk;
    tk = (cyc % 3) == 2;
    strobe_n = sn; sw_req = sw; rpt_ack = ack; tick = tk;
    @(posedge clk);
    model_edge(sn, sw, ack, tk);
    cyc++;
    @(negedge clk);
    check(rpt_req === m_req, {tag, " rpt_req"}, rpt_req, m_req);
    check(rpt_time === m_time[TS_W-1:0], {tag, " rpt_time"}, rpt_time, m_time);
    check(rpt_src === m_src, {tag, " rpt_src"}, rpt_src, m_src);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    longint held;
    rst_n = 1'b0; tick = 1'b0; strobe_n = 1'b1; sw_req = 1'b0; rpt_ack = 1'b0;
    hist = '{1, 1, 1};
    m_low = 0; m_cnt = 0; m_time = 0; m_req = 0; m_src = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(rpt_req === 1'b0, "R1 reset req", rpt_req, 0);
    check(rpt_time === '0, "R1 reset time", rpt_time, 0);
    check(rpt_src === 1'b0, "R1 reset src", rpt_src, 0);

    // R2 / R6: read request after counter has advanced
    idle(20, "R2 idle");
    step(1'b1, 1'b1, 1'b0, "R6 sw capture");
    check(rpt_req && !rpt_src, "R6 sw source", rpt_src, 0);
    check(rpt_time == TS_W'(m_cnt - ((cyc % 3) == 0 ? 1 : 0)), "R2 counter value", rpt_time, m_time);
    idle(4, "R8 hold");
    step(1'b1, 1'b0, 1'b1, "R9 ack");
    check(!rpt_req, "R9 ack clears", rpt_req, 0);
    step(1'b1, 1'b0, 1'b1, "R9 stray ack");
    idle(5, "R2 idle");

    // R3: long pulse then release, exact latency
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b0, "R4 low");
    check(!rpt_req, "R4 falling edge no capture", rpt_req, 0);
    step(1'b1, 1'b0, 1'b0, "R3 release");
    step(1'b1, 1'b0, 1'b0, "R3 sync1");
    check(!rpt_req, "R3 not early", rpt_req, 0);
    step(1'b1, 1'b0, 1'b0, "R3 sync2");
    check(rpt_req && rpt_src, "R3 pin capture at third edge", rpt_req, 1);
    held = rpt_time;

    // R8: activity while pending
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, "R8 low while pending");
    idle(4, "R8 release while pending");
    step(1'b1, 1'b1, 1'b0, "R8 sw while pending");
    idle(3, "R8 hold");
    check(rpt_time == held && rpt_src, "R8 held value", rpt_time, held);
    step(1'b1, 1'b0, 1'b1, "R9 ack pin");
    idle(6, "R9 after ack");

    // R5: short glitch (2 ticks)
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, "R5 short low");
    idle(6, "R5 short release");
    check(!rpt_req, "R5 glitch rejected", rpt_req, 0);

    // R7: valid release coinciding with read request
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, "R7 low");
    step(1'b1, 1'b0, 1'b0, "R7 release");
    step(1'b1, 1'b0, 1'b0, "R7 sync");
    step(1'b1, 1'b1, 1'b0, "R7 same edge");
    check(rpt_req && rpt_src, "R7 pin wins", rpt_src, 1);
    step(1'b1, 1'b0, 1'b1, "R7 single ack");
    idle(3, "R7 after ack");
    check(!rpt_req, "R7 one ack ends report", rpt_req, 0);

    // R9: capture immediately after ack edge; ack edge itself takes none
    step(1'b1, 1'b1, 1'b0, "R6 sw again");
    step(1'b1, 1'b1, 1'b1, "R9 ack with sw");
    check(!rpt_req, "R9 no capture on ack edge", rpt_req, 0);
    step(1'b1, 1'b1, 1'b0, "R9 capture after ack");
    check(rpt_req && !rpt_src, "R9 new capture", rpt_req, 1);
    step(1'b1, 1'b0, 1'b1, "R9 ack");
    idle(5, "R2 tail");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule